// File: doc/BRIEF.md
# Reloading Interval Timer with Toggle Output

A single down-counting timer channel with a small register interface. Software loads a period, picks one of four prescaled tick rates, and starts the channel with a self-clearing trigger bit. On every tick the count drops by one. When the count is already zero, the next tick reloads the period, raises a one-cycle interrupt pulse and toggles a square-wave output. A second self-clearing trigger stops the channel. The count and the output level both freeze at the moment of the stop.

A mode bit decides whether the start itself also raises an interrupt and toggles the output. While output enable is clear, the output simply shows the level that software last wrote. While it is set, the toggle logic drives the output. The mode register is locked while the channel runs. The period and output registers stay writable at all times. A period change takes effect at the next reload.

Top module: `interval_timer`

## Requirements
- R1: After reset the channel is stopped, the count reads all ones, the period reads all ones, the output and output enable are 0, and the interrupt is low.
- R2: Writing register 2 (CTRL) with bit 0 set sets the running flag (CTRL read bit 2) and loads the period into the count. CTRL bits 0 and 1 always read 0.
- R3: When MODE bit 2 is 1, a start raises a one-cycle interrupt and toggles the output (if output enable is 1). When that bit is 0, a start does neither.
- R4: While running, each selected tick decrements the count. A tick at count 0 reloads the period, pulses the interrupt for one cycle and toggles the output when enabled, so interrupts come every period+1 ticks.
- R5: A period write (register 0) while running changes no count value until the next reload from zero, which uses the new value.
- R6: Writing CTRL with bit 1 set clears the running flag. The count and the output keep their values while stopped.
- R7: A CTRL write with bits 0 and 1 both set acts as a stop.
- R8: A write to register 4 (OUT) sets the output level from bit 0 and output enable from bit 1. This write has priority over a toggle in the same cycle. With output enable 0, no toggles occur.
- R9: While running, writes to register 3 (MODE) are ignored. Period and OUT writes still take effect.
- R10: MODE bits [1:0] = k select a tick every 2^(k*STEP) cycles, on the cycles where a free-running cycle index (0 at the first edge after reset) modulo that divisor equals divisor-1. Register 1 reads the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address (read and write) |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Combinational read data for addr_i |
| irq_o | output | 1 | One-cycle interrupt pulse |
| tout_o | output | 1 | Square-wave / software level output |

## Verification
The bench builds the block with CNT_W=8 and STEP=2. With these values the slowest tick divisor is 64 and a full count range is 256, so reloads on every clock-select setting occur within a few hundred cycles. The narrow count also makes the all-ones reset value and the wrap behaviour at zero easy to reach. Period 0 on the undivided tick exercises the case where an interrupt fires on every cycle.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [2:0] {
    REG_PERIOD = 3'd0,
    REG_COUNT  = 3'd1,
    REG_CTRL   = 3'd2,
    REG_MODE   = 3'd3,
    REG_OUT    = 3'd4
  } reg_addr_e;

  localparam int unsigned CTRL_START_BIT = 0;
  localparam int unsigned CTRL_STOP_BIT  = 1;
  localparam int unsigned CTRL_RUN_BIT   = 2;
  localparam int unsigned MODE_IAS_BIT   = 2;
  localparam int unsigned OUT_LVL_BIT    = 0;
  localparam int unsigned OUT_OE_BIT     = 1;
  localparam int unsigned NUM_SEL        = 4;
endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int unsigned STEP = 2,
  parameter int unsigned NSEL = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [NSEL-1:0] tick_o
);
  localparam int unsigned PRE_W = STEP * (NSEL - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  for (genvar k = 0; k < NSEL; k++) begin : g_tap
    if (k == 0) begin : g_full
      assign tick_o[k] = 1'b1;
    end else begin : g_div
      assign tick_o[k] = &pre_q[k*STEP-1:0];
    end
  end
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             ias_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             running_o,
  output logic             fire_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             irq_q;
  logic             fire;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    fire  = 1'b0;
    if (stop_i) begin
      run_d = 1'b0;            // stop wins over a simultaneous start
    end else if (start_i) begin
      run_d = 1'b1;
      cnt_d = period_i;
      fire  = ias_i;
    end else if (run_q && tick_i) begin
      if (cnt_q == '0) begin
        cnt_d = period_i;
        fire  = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      run_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      irq_q <= fire;
    end
  end

  assign cnt_o     = cnt_q;
  assign running_o = run_q;
  assign fire_o    = fire;
  assign irq_o     = irq_q;

  assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && tick_i && cnt_q == '0 && !start_i && !stop_i)
      |=> (cnt_q == $past(period_i)) && irq_q);

  assert_decrement_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && tick_i && cnt_q != '0 && !start_i && !stop_i)
      |=> (cnt_q == $past(cnt_q) - 1'b1) && !irq_q);

  assert_stop_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !start_i) |=> $stable(cnt_q));

  assert_stop_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && stop_i) |=> !run_q && !irq_q);
endmodule

// File: rtl/timer_output.sv
module timer_output (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic level_i,
  input  logic oe_i,
  input  logic toggle_i,
  output logic out_o,
  output logic oe_o
);
  logic out_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (wr_i) begin
      out_q <= level_i;
      oe_q  <= oe_i;
    end else if (toggle_i && oe_q) begin
      out_q <= ~out_q;
    end
  end

  assign out_o = out_q;
  assign oe_o  = oe_q;

  assert_sw_level_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_q && !wr_i) |=> $stable(out_q));

  assert_sw_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (out_q == $past(level_i)) && (oe_q == $past(oe_i)));
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned STEP  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [2:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o,
  output logic             tout_o
);
  import timer_pkg::*;

  localparam int unsigned SEL_W = $clog2(NUM_SEL);

  logic [CNT_W-1:0]   period_q;
  logic [SEL_W-1:0]   sel_q;
  logic               ias_q;
  logic [NUM_SEL-1:0] ticks;
  logic [CNT_W-1:0]   cnt;
  logic               running, fire, oe;
  logic               wr_period, wr_ctrl, wr_mode, wr_out;
  logic               start, stop;

  assign wr_period = wr_i && (addr_i == REG_PERIOD);
  assign wr_ctrl   = wr_i && (addr_i == REG_CTRL);
  assign wr_mode   = wr_i && (addr_i == REG_MODE);
  assign wr_out    = wr_i && (addr_i == REG_OUT);
  assign start     = wr_ctrl && wdata_i[CTRL_START_BIT];
  assign stop      = wr_ctrl && wdata_i[CTRL_STOP_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '1;
      sel_q    <= '0;
      ias_q    <= 1'b0;
    end else begin
      if (wr_period) period_q <= wdata_i;
      if (wr_mode && !running) begin   // mode locked while running
        sel_q <= wdata_i[SEL_W-1:0];
        ias_q <= wdata_i[MODE_IAS_BIT];
      end
    end
  end

  timer_prescaler #(.STEP(STEP), .NSEL(NUM_SEL)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (ticks)
  );

  timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (ticks[sel_q]),
    .start_i   (start),
    .stop_i    (stop),
    .ias_i     (ias_q),
    .period_i  (period_q),
    .cnt_o     (cnt),
    .running_o (running),
    .fire_o    (fire),
    .irq_o     (irq_o)
  );

  timer_output u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_out),
    .level_i  (wdata_i[OUT_LVL_BIT]),
    .oe_i     (wdata_i[OUT_OE_BIT]),
    .toggle_i (fire),
    .out_o    (tout_o),
    .oe_o     (oe)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_PERIOD: rdata_o = period_q;
      REG_COUNT:  rdata_o = cnt;
      REG_CTRL:   rdata_o[CTRL_RUN_BIT] = running;
      REG_MODE: begin
        rdata_o[SEL_W-1:0]   = sel_q;
        rdata_o[MODE_IAS_BIT] = ias_q;
      end
      REG_OUT: begin
        rdata_o[OUT_LVL_BIT] = tout_o;
        rdata_o[OUT_OE_BIT]  = oe;
      end
      default: rdata_o = '0;
    endcase
  end

  assert_mode_lock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && wr_mode) |=> $stable(sel_q) && $stable(ias_q));

  assert_period_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_period |=> period_q == $past(wdata_i));
endmodule

// File: tb/sim_interval_timer.sv
module sim_interval_timer;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned STEP  = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr = 1'b0;
  logic [2:0]       addr = 3'd0;
  logic [CNT_W-1:0] wdata = '0;
  logic [CNT_W-1:0] rdata;
  logic             irq, tout;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  interval_timer #(.CNT_W(CNT_W), .STEP(STEP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .tout_o(tout)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  int m_period, m_cnt, m_sel, cyc;
  bit m_run, m_ias, m_out, m_oe, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_period = (1 << CNT_W) - 1; m_cnt = m_period; m_sel = 0; cyc = 0;
      m_run = 0; m_ias = 0; m_out = 0; m_oe = 0; m_irq = 0;
    end else begin
      int  div;
      bit  tick, st, sp, fire;
      int  n_cnt, n_period, n_sel;
      bit  n_run, n_ias, n_out, n_oe;
      div  = 1 << (m_sel * STEP);
      tick = (cyc % div) == div - 1;
      st   = wr && addr == 3'd2 && wdata[0];
      sp   = wr && addr == 3'd2 && wdata[1];
      n_cnt = m_cnt; n_run = m_run; fire = 0;
      if (sp) n_run = 0;
      else if (st) begin n_run = 1; n_cnt = m_period; fire = m_ias; end
      else if (m_run && tick) begin
        if (m_cnt == 0) begin n_cnt = m_period; fire = 1; end
        else n_cnt = m_cnt - 1;
      end
      n_period = m_period; n_sel = m_sel; n_ias = m_ias;
      if (wr && addr == 3'd0) n_period = int'(wdata);
      if (wr && addr == 3'd3 && !m_run) begin n_sel = int'(wdata[1:0]); n_ias = wdata[2]; end
      n_out = m_out; n_oe = m_oe;
      if (wr && addr == 3'd4) begin n_out = wdata[0]; n_oe = wdata[1]; end
      else if (fire && m_oe) n_out = ~m_out;
      m_cnt = n_cnt; m_run = n_run; m_irq = fire; m_period = n_period;
      m_sel = n_sel; m_ias = n_ias; m_out = n_out; m_oe = n_oe;
      cyc++;
    end
  end

  function automatic int model_read(input logic [2:0] a);
    case (a)
      3'd0: return m_period;
      3'd1: return m_cnt;
      3'd2: return int'(m_run) << 2;
      3'd3: return m_sel | (int'(m_ias) << 2);
      3'd4: return int'(m_out) | (int'(m_oe) << 1);
      default: return 0;
    endcase
  endfunction

  task automatic compare();
    checks++;
    if (irq !== m_irq) begin
      fails++; $display("FAIL %s irq act=%0d exp=%0d", cur_req, irq, m_irq);
    end
    checks++;
    if (tout !== m_out) begin
      fails++; $display("FAIL %s tout act=%0d exp=%0d", cur_req, tout, m_out);
    end
    checks++;
    if (int'(rdata) !== model_read(addr)) begin
      fails++; $display("FAIL %s rdata[a=%0d] act=%0d exp=%0d", cur_req, addr, rdata, model_read(addr));
    end
  endtask

  task automatic cycle(input logic w, input logic [2:0] a, input int d);
    @(negedge clk);
    compare();
    wr = w; addr = a; wdata = CNT_W'(d);
  endtask

  task automatic wreg(input logic [2:0] a, input int d);
    cycle(1'b1, a, d);
  endtask

  task automatic idle(input logic [2:0] a, input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, a, 0);
  endtask

  // explicit value check at the ports
  task automatic expect_rd(input logic [2:0] a, input int exp, input string req);
    cycle(1'b0, a, 0);
    @(negedge clk);
    checks++;
    if (int'(rdata) !== exp) begin
      fails++; $display("FAIL %s explicit a=%0d act=%0d exp=%0d", req, a, rdata, exp);
    end
    compare();
    wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (%s)", cur_req);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    cur_req = "R1";
    expect_rd(3'd0, 255, "R1");
    expect_rd(3'd1, 255, "R1");
    expect_rd(3'd2, 0, "R1");
    expect_rd(3'd4, 0, "R1");

    cur_req = "R2";
    wreg(3'd0, 5);
    wreg(3'd3, 0);
    wreg(3'd4, 2);             // oe=1, level 0
    wreg(3'd2, 1);             // start
    expect_rd(3'd2, 4, "R2");  // running, trigger bits read 0
    cur_req = "R4";
    idle(3'd1, 30);

    cur_req = "R5";
    wreg(3'd0, 2);
    idle(3'd1, 20);

    cur_req = "R6";
    wreg(3'd2, 2);
    idle(3'd1, 8);
    expect_rd(3'd2, 0, "R6");
    idle(3'd4, 5);

    cur_req = "R3";
    wreg(3'd3, 4);             // ias=1, sel 0
    wreg(3'd2, 1);
    idle(3'd4, 10);
    wreg(3'd2, 2);
    wreg(3'd3, 0);             // ias=0
    wreg(3'd2, 1);
    idle(3'd4, 3);

    cur_req = "R9";
    wreg(3'd3, 7);             // ignored while running
    expect_rd(3'd3, 0, "R9");
    wreg(3'd0, 1);
    expect_rd(3'd0, 1, "R9");

    cur_req = "R8";
    wreg(3'd4, 1);             // oe=0, level 1
    idle(3'd4, 12);
    wreg(3'd4, 2);
    idle(3'd4, 12);

    cur_req = "R7";
    wreg(3'd2, 3);
    expect_rd(3'd2, 0, "R7");
    idle(3'd1, 4);

    cur_req = "R10";
    wreg(3'd0, 2);
    for (int s = 1; s < 4; s++) begin
      wreg(3'd3, s);
      wreg(3'd2, 1);
      idle(3'd1, (s == 3) ? 400 : 120);
      wreg(3'd2, 2);
    end

    cur_req = "R4";
    wreg(3'd3, 0);
    wreg(3'd0, 0);             // interrupt every cycle
    wreg(3'd2, 1);
    idle(3'd4, 10);
    wreg(3'd2, 2);
    idle(3'd1, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule